// File: doc/BRIEF.md
# Parallel I/O Bank Controller with Atomic Set/Clear Configuration

This block manages one bank of 32 general-purpose pins behind a simple memory-mapped write/read bus. Each pin has six configuration attributes:

- GPIO versus peripheral ownership.
- Which of two peripherals (A or B) drives the pin when it is not under GPIO control.
- Output enable.
- Output data.
- Pull-up enable.
- Open-drain (multi-drive) enable.

Software never rewrites a whole attribute word. Each attribute has one address where a 1 bit sets the matching pins and another address where a 1 bit clears them. Bits written as 0 leave their pins alone, so no read-modify-write is needed and concurrent users of different pins cannot disturb each other. A third address returns the current attribute word.

The pad side gets `pad_out`, `pad_oe` and `pad_pullup` for each pin. A pin under GPIO control drives its own data and enable. Otherwise the pin forwards the data and enable of peripheral A or peripheral B. Open-drain mode is applied after that selection: the pad is then driven only while the chosen data is 0. The pad level passes through a two-flop synchronizer and can be read back whatever the pin's owner.

Top module: `pio_bank_ctrl`

## Requirements
- R1: After reset every pin is GPIO-owned, peripheral A is selected, output enable is 0, output data is 0, pull-up is 1 and open-drain is 0. `pad_oe` is all zero and `pad_pullup` is all ones.
- R2: A write to 0x00 makes the 1-bit pins GPIO-owned. A write to 0x04 hands the 1-bit pins to a peripheral. 0x08 reads ownership with 1 = GPIO. Zero bits leave their pins unchanged.
- R3: A write to 0x74 selects peripheral B for the 1-bit pins. A write to 0x70 selects peripheral A. 0x78 reads the selection with 1 = B and 0 = A.
- R4: A write to 0x30 sets output data for the 1-bit pins. A write to 0x34 clears it. 0x38 reads the output data. Zero bits leave their pins unchanged.
- R5: A write to 0x10 enables output drive for the 1-bit pins. A write to 0x14 disables it. 0x18 reads the output-enable word.
- R6: With open-drain off, a GPIO-owned pin drives `pad_out`/`pad_oe` from its output data and enable. A peripheral-owned pin drives them from `pa_out`/`pa_oe` when A is selected and from `pb_out`/`pb_oe` when B is selected.
- R7: Address 0x3C reads `pad_in` as sampled two clock edges earlier, for every pin regardless of owner.
- R8: A write to 0x64 enables pull-up for the 1-bit pins. A write to 0x60 disables it. 0x68 reads the pull-up word, and `pad_pullup` equals that word.
- R9: A write to 0x50 enables open-drain for the 1-bit pins. A write to 0x54 disables it. 0x58 reads the open-drain word. For an open-drain pin, `pad_out` is 0 and `pad_oe` is the selected enable ANDed with the inverse of the selected data.
- R10: Writes to the status addresses (0x08, 0x18, 0x38, 0x3C, 0x58, 0x68, 0x78) or to unmapped addresses change no state, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pa_out | input | 32 | Peripheral A output data per pin |
| pa_oe | input | 32 | Peripheral A output enable per pin |
| pb_out | input | 32 | Peripheral B output data per pin |
| pb_oe | input | 32 | Peripheral B output enable per pin |
| pad_in | input | 32 | Pad level per pin, asynchronous |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pad pull-up enable |

## Verification
The bench builds the block with its default width of 32 pins, so the full word of set and clear masks, including the top bit, is exercised. Random masks are written to every set, clear, status and unmapped address while the peripheral inputs and pad levels change each cycle. This places every pin in all combinations of owner, selection and open-drain. It also makes the two-cycle synchronizer delay observable on pins owned by a peripheral.

// File: rtl/pio_bank_pkg.sv
// Package: register offsets for the I/O bank controller.
// Assumes byte addressing with word-aligned registers.
package pio_bank_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_OWN_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OWN_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OWN_RD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OE_SET  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OE_CLR  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_OE_RD   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_DAT_SET = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DAT_CLR = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_DAT_RD  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_PIN_RD  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_OD_SET  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_OD_CLR  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_OD_RD   = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_PU_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_PU_SET  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_PU_RD   = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_SEL_CLR = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_SEL_SET = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_SEL_RD  = 8'h78;
endpackage

// File: rtl/pio_setclr_reg.sv
// Per-bit attribute register updated by independent set and clear masks.
// Assumes set and clear never arrive in the same cycle; set wins if they do.
module pio_setclr_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Apply masks bitwise; zero bits hold their value.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/pio_in_sync.sv
// Two-flop synchronizer for the asynchronous pad levels.
// Assumes each pin is independent; no multi-bit coherence is implied.
module pio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;
    // Shift the pad levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/pio_pin_route.sv
// Per-pin output routing: GPIO or peripheral A/B source, then open-drain.
// Assumes all inputs are registered or stable within the cycle.
module pio_pin_route #(
    parameter int W = 32
) (
    input  logic [W-1:0] own_i,
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] dat_i,
    input  logic [W-1:0] oe_i,
    input  logic [W-1:0] od_i,
    input  logic [W-1:0] pa_out_i,
    input  logic [W-1:0] pa_oe_i,
    input  logic [W-1:0] pb_out_i,
    input  logic [W-1:0] pb_oe_i,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic src_out, src_oe;
        // Pick the owner of pin i.
        always_comb begin
            if (own_i[i]) begin
                src_out = dat_i[i];
                src_oe  = oe_i[i];
            end else if (sel_i[i]) begin
                src_out = pb_out_i[i];
                src_oe  = pb_oe_i[i];
            end else begin
                src_out = pa_out_i[i];
                src_oe  = pa_oe_i[i];
            end
        end
        // Open-drain drives low only; a 1 releases the pad.
        always_comb begin
            pad_out_o[i] = od_i[i] ? 1'b0 : src_out;
            pad_oe_o[i]  = od_i[i] ? (src_oe & ~src_out) : src_oe;
        end
    end
endmodule

// File: rtl/pio_bank_ctrl.sv
// One I/O bank: set/clear configuration registers, pad routing and pad
// readback. Assumes single-cycle writes and combinational reads.
module pio_bank_ctrl
    import pio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pullup
);
    localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};

    logic [NPINS-1:0] own_q, sel_q, oe_q, dat_q, pu_q, od_q, pin_q;
    logic [NPINS-1:0] own_s, own_c, sel_s, sel_c, oe_s, oe_c;
    logic [NPINS-1:0] dat_s, dat_c, pu_s, pu_c, od_s, od_c;

    // Decode a write into one set or clear mask.
    always_comb begin
        {own_s, own_c, sel_s, sel_c, oe_s, oe_c} = '0;
        {dat_s, dat_c, pu_s, pu_c, od_s, od_c}   = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_OWN_SET: own_s = bus_wdata;
                OFS_OWN_CLR: own_c = bus_wdata;
                OFS_SEL_SET: sel_s = bus_wdata;
                OFS_SEL_CLR: sel_c = bus_wdata;
                OFS_OE_SET:  oe_s  = bus_wdata;
                OFS_OE_CLR:  oe_c  = bus_wdata;
                OFS_DAT_SET: dat_s = bus_wdata;
                OFS_DAT_CLR: dat_c = bus_wdata;
                OFS_PU_SET:  pu_s  = bus_wdata;
                OFS_PU_CLR:  pu_c  = bus_wdata;
                OFS_OD_SET:  od_s  = bus_wdata;
                OFS_OD_CLR:  od_c  = bus_wdata;
                default: ;
            endcase
        end
    end

    pio_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_own (.clk(clk), .rst_n(rst_n), .set_i(own_s), .clr_i(own_c), .q_o(own_q));
    pio_setclr_reg #(.W(NPINS), .RST_VAL('0))   u_sel (.clk(clk), .rst_n(rst_n), .set_i(sel_s), .clr_i(sel_c), .q_o(sel_q));
    pio_setclr_reg #(.W(NPINS), .RST_VAL('0))   u_oe  (.clk(clk), .rst_n(rst_n), .set_i(oe_s),  .clr_i(oe_c),  .q_o(oe_q));
    pio_setclr_reg #(.W(NPINS), .RST_VAL('0))   u_dat (.clk(clk), .rst_n(rst_n), .set_i(dat_s), .clr_i(dat_c), .q_o(dat_q));
    pio_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_pu  (.clk(clk), .rst_n(rst_n), .set_i(pu_s),  .clr_i(pu_c),  .q_o(pu_q));
    pio_setclr_reg #(.W(NPINS), .RST_VAL('0))   u_od  (.clk(clk), .rst_n(rst_n), .set_i(od_s),  .clr_i(od_c),  .q_o(od_q));

    pio_in_sync #(.W(NPINS)) u_sync (.clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_q));

    pio_pin_route #(.W(NPINS)) u_route (
        .own_i(own_q), .sel_i(sel_q), .dat_i(dat_q), .oe_i(oe_q), .od_i(od_q),
        .pa_out_i(pa_out), .pa_oe_i(pa_oe), .pb_out_i(pb_out), .pb_oe_i(pb_oe),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    assign pad_pullup = pu_q;

    // Return the status word for the addressed register.
    always_comb begin
        case (bus_addr)
            OFS_OWN_RD: bus_rdata = own_q;
            OFS_SEL_RD: bus_rdata = sel_q;
            OFS_OE_RD:  bus_rdata = oe_q;
            OFS_DAT_RD: bus_rdata = dat_q;
            OFS_PIN_RD: bus_rdata = pin_q;
            OFS_PU_RD:  bus_rdata = pu_q;
            OFS_OD_RD:  bus_rdata = od_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pio_bank_ctrl_chk.sv
// Checker for the I/O bank controller, bound to every instance.
// Assumes the register offsets from pio_bank_pkg.
module pio_bank_ctrl_chk
    import pio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  own_q,
    input logic [NPINS-1:0]  dat_q,
    input logic [NPINS-1:0]  od_q,
    input logic [NPINS-1:0]  pin_q,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out
);
    logic [1:0] warm_cnt;
    // Count clock edges seen since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 3)  warm_cnt <= warm_cnt + 2'd1;
    end

    p_own_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OWN_CLR) |=> ((own_q & $past(bus_wdata)) == '0));

    p_data_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DAT_SET) |=> ((dat_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_pin_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 2) |-> (pin_q == $past(pad_in, 2)));

    p_status_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OWN_RD) |=> (own_q == $past(own_q)));

    p_opendrain_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_q & pad_out) == '0));

    p_gpio_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((own_q & ~od_q) & (pad_out ^ dat_q)) == '0));
endmodule

bind pio_bank_ctrl pio_bank_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .own_q(own_q), .dat_q(dat_q), .od_q(od_q),
    .pin_q(pin_q), .pad_in(pad_in), .pad_out(pad_out)
);

// File: tb/pio_bank_ctrl_test.sv
module pio_bank_ctrl_test;
    localparam int PERIOD = 20;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0, pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pullup;

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements.
    logic [N-1:0] m_own, m_sel, m_oe, m_dat, m_pu, m_od, m_s1, m_s2;

    always #(PERIOD/2) clk = ~clk;

    pio_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
    );

    function automatic logic [N-1:0] src_out();
        return (m_own & m_dat) | (~m_own & ~m_sel & pa_out) | (~m_own & m_sel & pb_out);
    endfunction
    function automatic logic [N-1:0] src_oe();
        return (m_own & m_oe) | (~m_own & ~m_sel & pa_oe) | (~m_own & m_sel & pb_oe);
    endfunction
    function automatic logic [N-1:0] exp_pad_out();
        return src_out() & ~m_od;
    endfunction
    function automatic logic [N-1:0] exp_pad_oe();
        return src_oe() & ~(m_od & src_out());
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req, input logic [N-1:0] exp);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // Check all status reads and pads; call just after a negedge.
    task automatic check_all();
        chk("R6/R9 pad_out", pad_out, exp_pad_out());
        chk("R6/R9 pad_oe", pad_oe, exp_pad_oe());
        chk("R8 pad_pullup", pad_pullup, m_pu);
        rd(8'h08, "R2 own", m_own);
        rd(8'h78, "R3 sel", m_sel);
        rd(8'h38, "R4 data", m_dat);
        rd(8'h18, "R5 oe", m_oe);
        rd(8'h3C, "R7 pin", m_s2);
        rd(8'h68, "R8 pullup", m_pu);
        rd(8'h58, "R9 opendrain", m_od);
        rd(8'h40, "R10 unmapped", '0);
    endtask

    // Apply a write to the model as the design should.
    task automatic model_write(input logic [7:0] a, input logic [N-1:0] d);
        case (a)
            8'h00: m_own |= d;
            8'h04: m_own &= ~d;
            8'h74: m_sel |= d;
            8'h70: m_sel &= ~d;
            8'h10: m_oe |= d;
            8'h14: m_oe &= ~d;
            8'h30: m_dat |= d;
            8'h34: m_dat &= ~d;
            8'h64: m_pu |= d;
            8'h60: m_pu &= ~d;
            8'h50: m_od |= d;
            8'h54: m_od &= ~d;
            default: ;
        endcase
    endtask

    // One write cycle; returns just after the following negedge.
    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        model_write(a, d);
        m_s2 = m_s1;
        m_s1 = pad_in;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    localparam int NADDR = 22;
    function automatic logic [7:0] pick_addr(input int k);
        logic [7:0] t [NADDR] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h30, 8'h34,
                                 8'h38, 8'h3C, 8'h50, 8'h54, 8'h58, 8'h60, 8'h64, 8'h68,
                                 8'h70, 8'h74, 8'h78, 8'h0C, 8'h44, 8'h30};
        return t[k];
    endfunction

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        m_own = '1; m_sel = '0; m_oe = '0; m_dat = '0; m_pu = '1; m_od = '0;
        m_s1 = '0; m_s2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the pads and in the status registers.
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_pullup", pad_pullup, '1);
        check_all();

        // Directed corner cases.
        wr(8'h30, 32'h8000_0001);
        check_all();                          // R4 data set edges
        wr(8'h10, 32'hFFFF_0000);
        check_all();                          // R5 oe set
        wr(8'h50, 32'h0000_0001);
        check_all();                          // R9 open-drain with data 1
        wr(8'h04, '1);
        check_all();                          // R2 all to peripheral A
        pb_out = 32'hA5A5_A5A5; pb_oe = 32'h0F0F_0F0F;
        wr(8'h74, 32'hFFFF_0000);
        check_all();                          // R3/R6 B select upper half
        wr(8'h08, '0);
        check_all();                          // R10 write to status ignored
        wr(8'h3C, '1);
        check_all();                          // R10 write to pin status ignored
        pad_in = 32'hDEAD_BEEF;
        wr(8'h44, '1);
        check_all();                          // R7 after one edge
        wr(8'h0C, '1);
        check_all();                          // R7 after two edges

        // Random traffic.
        for (int it = 0; it < 1500; it++) begin
            logic [N-1:0] d;
            pa_out = $urandom; pa_oe = $urandom; pb_out = $urandom; pb_oe = $urandom;
            pad_in = $urandom;
            case ($urandom_range(0, 5))
                0: d = '0;
                1: d = '1;
                default: d = $urandom;
            endcase
            wr(pick_addr($urandom_range(0, NADDR - 1)), d);
            check_all();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule